// File: doc/BRIEF.md
# Per-Channel PWM Output Generator

This block produces one high-side PWM signal for a single channel of a power-conversion PWM array. Two configuration bits choose where its timing comes from: the period is either the shared master period (with the shared master counter as the count), or the channel's own period value, which then drives a counter local to the channel. Independently, the duty value is taken either from the shared master duty input or from the channel's own duty input.

In edge-aligned operation the output is high during the early part of each period. In independent-period mode the channel can instead run center-aligned: its counter ramps up to the period and back down, and the pulse sits symmetrically around the counter's minimum. Duty values carry a fixed offset of 8 counts, with saturation at 0 % and 100 %. Three interrupt status flags (trigger, current limit, fault) latch their events and are cleared only by dropping their enables. The mode bits can be written only while the channel is disabled. While disabled, the output stays low.

Top module: `pwm_chan_gen`

## Requirements
- R1: After reset the output is low, all three status flags are 0, and the mode bits select shared period, channel duty and edge alignment.
- R2: An effective duty below 8 gives a constant low output, whatever the count.
- R3: An effective duty greater than the selected period plus 8 gives a constant high output, whatever the count.
- R4: In edge-aligned mode the output, one clock after a count value is presented, is high exactly when count + 8 < effective duty.
- R5: With the independent bit at 0, the shared period input and the shared count input set the timing. With it at 1, the channel period input and the local counter set the timing.
- R6: With the master-duty bit at 1, the shared duty input is the effective duty. With it at 0, the channel duty input is the effective duty.
- R7: In independent edge-aligned mode the local counter starts at 0 on the first enabled clock, steps by 1, and wraps to 0 after reaching the channel period.
- R8: In independent center-aligned mode the local counter runs 0 up to the period and back down to 0. The output is high while count < (duty with its 3 low bits cleared) - 8, so the 3 low duty bits have no effect.
- R9: With the independent bit at 0, the center-aligned bit has no effect and the channel stays edge-aligned.
- R10: Status flags are indexed bit 0 trigger, bit 1 current limit, bit 2 fault. A flag whose enable is 1 sets one clock after its event and stays set while the enable stays 1.
- R11: A flag whose enable is 0 reads 0 one clock later, and its events are ignored.
- R12: A mode-bit write made while the channel enable is 1 is ignored.
- R13: While the channel enable is 0 the output is low, and the local counter is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Channel enable |
| cfgWrite | input | 1 | Mode-bit write strobe |
| cfgIndep | input | 1 | Mode bit: own period and local counter |
| cfgDutyMaster | input | 1 | Mode bit: use the shared duty |
| cfgCenter | input | 1 | Mode bit: center-aligned (needs cfgIndep) |
| masterCount | input | CNT_W | Shared master counter value |
| masterPeriod | input | CNT_W | Shared master period |
| masterDuty | input | CNT_W | Shared master duty |
| chanPeriod | input | CNT_W | Channel own period |
| chanDuty | input | CNT_W | Channel own duty |
| irqEvent | input | 3 | Event pulses: trigger, current limit, fault |
| irqEnable | input | 3 | Per-flag enables |
| pwmHigh | output | 1 | High-side PWM output |
| irqFlag | output | 3 | Latched status flags |

## Verification
The bench builds the block with CNT_W = 10. This keeps every period the tests use, and the 8-count saturation thresholds just below and above them, within a few dozen clocks. The local counter can therefore be followed through several full wraps and up/down sweeps. Because periods stay small, both saturation edges (duty 7 versus 8, and period + 8 versus period + 9) can be placed exactly. The center-aligned pattern can be compared cycle by cycle for two duties that differ only in their low 3 bits.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
  localparam int DUTY_OFS  = 8;
  localparam int CA_DROP   = 3;
  localparam int IRQ_COUNT = 3;
  localparam int IRQ_TRIG  = 0;
  localparam int IRQ_CLIM  = 1;
  localparam int IRQ_FAULT = 2;

  typedef struct packed {
    logic outEn;
    logic useLocal;
    logic center;
    logic dutyMaster;
    logic cntClear;
    logic cntInc;
    logic cntDec;
  } pwmStrobe_t;
endpackage

// File: rtl/pwm_gen_ctrl.sv
module pwm_gen_ctrl
  import pwm_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 cfgWrite,
  input  logic                 cfgIndep,
  input  logic                 cfgDutyMaster,
  input  logic                 cfgCenter,
  input  logic                 atTop,
  input  logic                 atBottom,
  input  logic [IRQ_COUNT-1:0] irqEvent,
  input  logic [IRQ_COUNT-1:0] irqEnable,
  output logic [IRQ_COUNT-1:0] irqFlag,
  output pwmStrobe_t           strobes
);
  logic modeIndep, modeDutyMaster, modeCenter;
  logic centerEff, dirDown;

  // mode bits are frozen while the channel runs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeIndep      <= 1'b0;
      modeDutyMaster <= 1'b0;
      modeCenter     <= 1'b0;
    end else if (cfgWrite && !enable) begin
      modeIndep      <= cfgIndep;
      modeDutyMaster <= cfgDutyMaster;
      modeCenter     <= cfgCenter;
    end
  end

  assign centerEff = modeIndep & modeCenter;

  always_ff @(posedge clk) begin
    if (!rst_n)                             dirDown <= 1'b0;
    else if (!enable || !centerEff)         dirDown <= 1'b0;
    else if (!dirDown && atTop && !atBottom) dirDown <= 1'b1;
    else if (dirDown && atBottom)           dirDown <= 1'b0;
  end

  always_comb begin
    strobes            = '0;
    strobes.outEn      = enable;
    strobes.useLocal   = modeIndep;
    strobes.center     = centerEff;
    strobes.dutyMaster = modeDutyMaster;
    if (!enable || !modeIndep)  strobes.cntClear = 1'b1;
    else if (!centerEff) begin
      if (atTop) strobes.cntClear = 1'b1;
      else       strobes.cntInc   = 1'b1;
    end
    else if (atTop && atBottom) strobes.cntClear = 1'b1;
    else if (!dirDown) begin
      if (atTop) strobes.cntDec = 1'b1;
      else       strobes.cntInc = 1'b1;
    end else begin
      if (atBottom) strobes.cntInc = 1'b1;
      else          strobes.cntDec = 1'b1;
    end
  end

  for (genvar i = 0; i < IRQ_COUNT; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)            irqFlag[i] <= 1'b0;
      else if (!irqEnable[i]) irqFlag[i] <= 1'b0;
      else if (irqEvent[i])  irqFlag[i] <= 1'b1;
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (irqEnable[i] && (irqEvent[i] || irqFlag[i])) |=> irqFlag[i]); // R10
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !irqEnable[i] |=> !irqFlag[i]); // R11
  end

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable({modeIndep, modeDutyMaster, modeCenter})); // R12
  AST_DIR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !dirDown); // R13
endmodule

// File: rtl/pwm_gen_dp.sv
module pwm_gen_dp
  import pwm_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pwmStrobe_t       strobes,
  input  logic [CNT_W-1:0] masterCount,
  input  logic [CNT_W-1:0] masterPeriod,
  input  logic [CNT_W-1:0] masterDuty,
  input  logic [CNT_W-1:0] chanPeriod,
  input  logic [CNT_W-1:0] chanDuty,
  output logic             atTop,
  output logic             atBottom,
  output logic             pwmHigh
);
  localparam logic [CNT_W:0]   OFS_X    = (CNT_W+1)'(DUTY_OFS);
  localparam logic [CNT_W-1:0] LSB_MASK = {{(CNT_W-CA_DROP){1'b1}}, {CA_DROP{1'b0}}};

  logic [CNT_W-1:0] localCnt, perSel, dutySel, effCnt;
  logic [CNT_W:0]   centerThr;
  logic             zeroSat, fullSat, edgeHit, centerHit, nextHigh;

  always_ff @(posedge clk) begin
    if (!rst_n)                 localCnt <= '0;
    else if (strobes.cntClear)  localCnt <= '0;
    else if (strobes.cntInc)    localCnt <= localCnt + 1'b1;
    else if (strobes.cntDec)    localCnt <= localCnt - 1'b1;
  end

  assign atTop    = (localCnt >= chanPeriod);
  assign atBottom = (localCnt == '0);

  assign perSel  = strobes.useLocal   ? chanPeriod : masterPeriod;
  assign dutySel = strobes.dutyMaster ? masterDuty : chanDuty;
  assign effCnt  = strobes.useLocal   ? localCnt   : masterCount;

  assign zeroSat   = ({1'b0, dutySel} < OFS_X);
  assign fullSat   = ({1'b0, dutySel} > ({1'b0, perSel} + OFS_X));
  assign edgeHit   = (({1'b0, effCnt} + OFS_X) < {1'b0, dutySel});
  assign centerThr = {1'b0, dutySel & LSB_MASK} - OFS_X;
  assign centerHit = ({1'b0, effCnt} < centerThr);

  always_comb begin
    if (zeroSat)             nextHigh = 1'b0;
    else if (fullSat)        nextHigh = 1'b1;
    else if (strobes.center) nextHigh = centerHit;
    else                     nextHigh = edgeHit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pwmHigh <= 1'b0;
    else        pwmHigh <= strobes.outEn & nextHigh;
  end

  AST_ZERO_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    zeroSat |=> !pwmHigh); // R2
  AST_FULL_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (fullSat && strobes.outEn) |=> pwmHigh); // R3
  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.outEn |=> (!pwmHigh && localCnt == '0)); // R13
endmodule

// File: rtl/pwm_chan_gen.sv
module pwm_chan_gen
  import pwm_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 cfgWrite,
  input  logic                 cfgIndep,
  input  logic                 cfgDutyMaster,
  input  logic                 cfgCenter,
  input  logic [CNT_W-1:0]     masterCount,
  input  logic [CNT_W-1:0]     masterPeriod,
  input  logic [CNT_W-1:0]     masterDuty,
  input  logic [CNT_W-1:0]     chanPeriod,
  input  logic [CNT_W-1:0]     chanDuty,
  input  logic [IRQ_COUNT-1:0] irqEvent,
  input  logic [IRQ_COUNT-1:0] irqEnable,
  output logic                 pwmHigh,
  output logic [IRQ_COUNT-1:0] irqFlag
);
  pwmStrobe_t strobes;
  logic       atTop, atBottom;

  pwm_gen_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfgWrite(cfgWrite),
    .cfgIndep(cfgIndep), .cfgDutyMaster(cfgDutyMaster), .cfgCenter(cfgCenter),
    .atTop(atTop), .atBottom(atBottom), .irqEvent(irqEvent),
    .irqEnable(irqEnable), .irqFlag(irqFlag), .strobes(strobes)
  );

  pwm_gen_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .masterCount(masterCount),
    .masterPeriod(masterPeriod), .masterDuty(masterDuty),
    .chanPeriod(chanPeriod), .chanDuty(chanDuty),
    .atTop(atTop), .atBottom(atBottom), .pwmHigh(pwmHigh)
  );
endmodule

// File: tb/sim_pwm_chan_gen.sv
module sim_pwm_chan_gen;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, cfgWrite = 1'b0;
  logic cfgIndep = 1'b0, cfgDutyMaster = 1'b0, cfgCenter = 1'b0;
  logic [W-1:0] masterCount = '0, masterPeriod = '0, masterDuty = '0;
  logic [W-1:0] chanPeriod = '0, chanDuty = '0;
  logic [2:0] irqEvent = '0, irqEnable = '0;
  logic pwmHigh;
  logic [2:0] irqFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pwm_chan_gen #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfgWrite(cfgWrite),
    .cfgIndep(cfgIndep), .cfgDutyMaster(cfgDutyMaster), .cfgCenter(cfgCenter),
    .masterCount(masterCount), .masterPeriod(masterPeriod), .masterDuty(masterDuty),
    .chanPeriod(chanPeriod), .chanDuty(chanDuty), .irqEvent(irqEvent),
    .irqEnable(irqEnable), .pwmHigh(pwmHigh), .irqFlag(irqFlag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit model(input int cnt, input int duty, input int per, input bit ctr);
    if (duty < 8) return 0;
    if (duty > per + 8) return 1;
    if (ctr) return cnt < ((duty & ~7) - 8);
    return (cnt + 8) < duty;
  endfunction

  task automatic setMode(input bit ind, input bit dm, input bit ctr);
    @(negedge clk);
    enable = 0; cfgWrite = 1;
    cfgIndep = ind; cfgDutyMaster = dm; cfgCenter = ctr;
    @(negedge clk);
    cfgWrite = 0;
  endtask

  // present one shared count value, sample one clock later
  task automatic masterStep(input string req, input int c, input int exp);
    @(negedge clk);
    masterCount = W'(c);
    @(posedge clk); #1;
    check(req, pwmHigh, exp);
  endtask

  task automatic testReset();
    check("R1 out", pwmHigh, 0);
    check("R1 flags", irqFlag, 0);
    // default modes: shared count, channel duty, edge
    @(negedge clk);
    enable = 1; masterPeriod = 40; chanDuty = 20; masterDuty = 0; chanPeriod = 100;
    masterStep("R1 default modes", 5, 1);
  endtask

  task automatic testMasterEdge();
    setMode(0, 0, 0);
    @(negedge clk); enable = 1; masterPeriod = 40; chanPeriod = 3; chanDuty = 20;
    masterStep("R4 c0", 0, 1);
    masterStep("R4 c11", 11, 1);
    masterStep("R4 c12", 12, 0);
    masterStep("R4 c30", 30, 0);
    chanDuty = 7;  masterStep("R2 duty7", 0, 0);
    chanDuty = 8;  masterStep("R2 duty8 c0", 0, 0);
    chanDuty = 9;  masterStep("R2 duty9 c0", 0, 1);
    chanDuty = 48; masterStep("R3 duty=per+8", 40, 0);
    chanDuty = 49; masterStep("R3 duty>per+8 R5", 40, 1);
  endtask

  task automatic testDutySel();
    setMode(0, 1, 0);
    @(negedge clk); enable = 1; masterDuty = 30; chanDuty = 0;
    masterStep("R6 c21", 21, 1);
    masterStep("R6 c22", 22, 0);
    // mode write while running must not take
    @(negedge clk); cfgWrite = 1; cfgIndep = 1; cfgDutyMaster = 0; cfgCenter = 1;
    @(negedge clk); cfgWrite = 0;
    masterStep("R12 still shared duty", 10, 1);
    masterStep("R12 still shared count", 25, 0);
    // disable: output low even at full saturation
    @(negedge clk); enable = 0; masterDuty = 900;
    @(posedge clk); #1; check("R13 off", pwmHigh, 0);
  endtask

  task automatic runLocal(input string req, input int per, input int duty,
                          input bit ctr, input int n);
    int m = 0;
    bit down = 0;
    @(negedge clk); enable = 0; chanPeriod = W'(per); chanDuty = W'(duty);
    masterPeriod = 300;
    @(negedge clk); enable = 1;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      check(req, pwmHigh, model(m, duty, per, ctr));
      if (!ctr) m = (m >= per) ? 0 : m + 1;
      else if (per == 0) m = 0;
      else if (!down) begin
        if (m >= per) begin m = m - 1; down = 1; end else m = m + 1;
      end else begin
        if (m == 0) begin m = 1; down = 0; end else m = m - 1;
      end
    end
  endtask

  task automatic testIndep();
    setMode(1, 0, 0);
    runLocal("R7 R5 local wrap", 9, 12, 0, 25);
    setMode(1, 0, 1);
    runLocal("R8 center duty19", 10, 19, 1, 42);
    runLocal("R8 center duty16", 10, 16, 1, 22);
    // restart from zero after a disable
    runLocal("R13 restart", 10, 16, 1, 6);
  endtask

  task automatic testCenterIgnored();
    setMode(0, 0, 1);
    @(negedge clk); enable = 1; masterPeriod = 40; chanDuty = 23;
    masterStep("R9 c14", 14, 1);
    masterStep("R9 c15", 15, 0);
  endtask

  task automatic testFlags();
    @(negedge clk); irqEnable = 3'b111; irqEvent = 3'b000;
    @(posedge clk); #1; check("R10 idle", irqFlag, 0);
    @(negedge clk); irqEvent = 3'b101;
    @(posedge clk); #1; check("R10 set", irqFlag, 5);
    @(negedge clk); irqEvent = 3'b000;
    @(posedge clk); #1; check("R10 hold", irqFlag, 5);
    @(negedge clk); irqEnable = 3'b110;
    @(posedge clk); #1; check("R11 clear trig", irqFlag, 4);
    @(negedge clk); irqEvent = 3'b011;
    @(posedge clk); #1; check("R11 ignore trig R10 clim", irqFlag, 6);
    @(negedge clk); irqEvent = 3'b000; irqEnable = 3'b000;
    @(posedge clk); #1; check("R11 all clear", irqFlag, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    testReset();
    testMasterEdge();
    testDutySel();
    testIndep();
    testCenterIgnored();
    testFlags();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule